// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of an I/O controller. A host reaches it through a pair of byte-wide ports on a 16-bit address bus: an index port at the pair's base address and a data port at base + 1. The pair can sit at a primary or an alternate base, chosen by a strap input. The port pair starts locked. It opens only after the unlock key has been written to the index port twice, one write right after the other. Once the pair is open, the index port picks a register number and the data port reads or writes that register. Writing the lock key to the index port closes the pair again.

A global device-select register chooses which logical device's bank the per-device register numbers reach. Each bank holds four bytes: an enable byte, a 16-bit base address split into a high and a low byte, and an IRQ select byte. The block drives each device's enable bit, base address and IRQ byte as outputs. Two read-only 16-bit identity values, a chip ID and a vendor ID, are readable as high and low bytes.

The unlock logic is a three-state machine:
- LOCKED: the reset state.
- ARMED: one unlock key has been seen.
- OPEN: register access is allowed.

The transitions are:
- arm: LOCKED to ARMED, on an index write of the unlock key.
- unlock: ARMED to OPEN, on an index write of the unlock key.
- abort: ARMED to LOCKED, on an index write of any other value.
- relock: OPEN to LOCKED, on an index write of the lock key.

Data-port traffic never moves the machine.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the state is LOCKED and cfg_open is 0. Every device byte is 0x00, and every read returns 0xFF.
- R2: Two index-port writes of UNLOCK_KEY (default 0x87), taken as consecutive index writes, set cfg_open to 1 from the next cycle. Data-port accesses between the two keys neither help nor break the sequence.
- R3: In LOCKED or ARMED, data-port writes have no effect and reads of either port return 0xFF. In ARMED, an index write of any value other than UNLOCK_KEY returns the state to LOCKED.
- R4: In OPEN, an index write of LOCK_KEY (default 0xAA) clears cfg_open from the next cycle. It does not become the index, and the index is 0x00 the next time the pair opens.
- R5: In OPEN, any other index write sets the index register. A read of the index port returns the index, and a data-port access reaches the register the index names.
- R6: Register 0x07 holds the logical device number. For the selected device: 0x30 is the enable byte (bit 0 drives dev_enable), 0x60 and 0x61 are the base high and low bytes (dev_base = {high, low}), and 0x70 is the IRQ byte. All of these read back all 8 bits as written, so a read-modify-write of one bit leaves the others intact.
- R7: When the device number is NUM_DEV or above, the bank registers read 0xFF and writes to them change no device.
- R8: Registers 0x20/0x21 return CHIP_ID high/low and 0x22/0x23 return VENDOR_ID high/low. Writes to them have no effect.
- R9: When alt_base is 0, the pair at PRI_BASE is active. When alt_base is 1, the pair at ALT_BASE is active. Reads of any other address, including the inactive pair, return 0xFF, and writes there (keys included) have no effect.
- R10: A read and a write to the same port in the same cycle return the value held before the write. The write takes effect from the next cycle.
- R11: In OPEN, register numbers not listed above read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alt_base | input | 1 | Strap: 0 selects the primary pair, 1 selects the alternate pair |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte, combinational, 0xFF when not driven |
| cfg_open | output | 1 | High while in OPEN |
| dev_enable | output | NUM_DEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each device, device 0 in the low bits |
| dev_irq | output | 8*NUM_DEV | IRQ select byte of each device |

## Verification
Two functions can meet in one cycle: a read and a write to the same port. Examples are reading the IRQ register while overwriting it, or reading the index port while the lock key is written to it. The bench raises both strobes together. It compares the returned byte against its model's value from before the write, and checks on the following clock that the write did land. Every cycle also compares cfg_open and all device outputs against the behavioural model.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED,
        ST_ARMED,
        ST_OPEN
    } key_state_e;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_EN,
        FLD_BHI,
        FLD_BLO,
        FLD_IRQ
    } field_e;

    localparam logic [7:0] REG_LDN     = 8'h07;
    localparam logic [7:0] REG_CHIP_HI = 8'h20;
    localparam logic [7:0] REG_CHIP_LO = 8'h21;
    localparam logic [7:0] REG_VEND_HI = 8'h22;
    localparam logic [7:0] REG_VEND_LO = 8'h23;
    localparam logic [7:0] REG_EN      = 8'h30;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;
    localparam logic [7:0] REG_IRQ     = 8'h70;

    function automatic field_e decode_field(input logic [7:0] idx);
        field_e f;
        case (idx)
            REG_EN:      f = FLD_EN;
            REG_BASE_HI: f = FLD_BHI;
            REG_BASE_LO: f = FLD_BLO;
            REG_IRQ:     f = FLD_IRQ;
            default:     f = FLD_NONE;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/kcp_key_fsm.sv
module kcp_key_fsm
    import kcp_pkg::*;
#(
    parameter logic [7:0] UNLOCK_KEY = 8'h87,
    parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open
);

    key_state_e state_q;
    key_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (idx_wr && wdata == UNLOCK_KEY) state_d = ST_ARMED;
            ST_ARMED:  if (idx_wr) state_d = (wdata == UNLOCK_KEY) ? ST_OPEN : ST_LOCKED;
            ST_OPEN:   if (idx_wr && wdata == LOCK_KEY) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        cfg_open = (state_q == ST_OPEN);
    end

    // R2
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && idx_wr && wdata == UNLOCK_KEY) |=> cfg_open);

    // R2
    open_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> ($past(state_q) == ST_ARMED && $past(idx_wr)));

    // R3
    arm_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && idx_wr && wdata != UNLOCK_KEY) |=> (state_q == ST_LOCKED));

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !idx_wr) |=> (state_q == ST_LOCKED));

    // R4
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && idx_wr && wdata == LOCK_KEY) |=> !cfg_open);

endmodule

// File: rtl/kcp_dev_bank.sv
module kcp_dev_bank
    import kcp_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DEV_W-1:0]      dev_sel,
    input  field_e                field,
    input  logic [7:0]            wdata,
    output logic [7:0]            rd_data,
    output logic [NUM_DEV-1:0]    dev_enable,
    output logic [16*NUM_DEV-1:0] dev_base,
    output logic [8*NUM_DEV-1:0]  dev_irq
);

    localparam int FLAT_W = 8 * NUM_DEV;

    logic [FLAT_W-1:0] en_flat;
    logic [FLAT_W-1:0] bhi_flat;
    logic [FLAT_W-1:0] blo_flat;
    logic [FLAT_W-1:0] irq_flat;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic [7:0] en_q;
        logic [7:0] bhi_q;
        logic [7:0] blo_q;
        logic [7:0] irq_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q  <= 8'h00;
                bhi_q <= 8'h00;
                blo_q <= 8'h00;
                irq_q <= 8'h00;
            end else if (wr_en && dev_sel == DEV_W'(g)) begin
                case (field)
                    FLD_EN:  en_q  <= wdata;
                    FLD_BHI: bhi_q <= wdata;
                    FLD_BLO: blo_q <= wdata;
                    FLD_IRQ: irq_q <= wdata;
                    default: ;
                endcase
            end
        end

        assign en_flat[g*8 +: 8]   = en_q;
        assign bhi_flat[g*8 +: 8]  = bhi_q;
        assign blo_flat[g*8 +: 8]  = blo_q;
        assign irq_flat[g*8 +: 8]  = irq_q;
        assign dev_enable[g]       = en_q[0];
        assign dev_base[g*16 +: 16] = {bhi_q, blo_q};
        assign dev_irq[g*8 +: 8]   = irq_q;
    end

    always_comb begin
        unique case (field)
            FLD_EN:  rd_data = en_flat[{dev_sel, 3'b000} +: 8];
            FLD_BHI: rd_data = bhi_flat[{dev_sel, 3'b000} +: 8];
            FLD_BLO: rd_data = blo_flat[{dev_sel, 3'b000} +: 8];
            FLD_IRQ: rd_data = irq_flat[{dev_sel, 3'b000} +: 8];
            default: rd_data = 8'h00;
        endcase
    end

    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(en_flat) && $stable(dev_base) && $stable(dev_irq)));

    // R6
    enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && field == FLD_EN) |=> (dev_enable[$past(dev_sel)] == $past(wdata[0])));

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import kcp_pkg::*;
#(
    parameter int          NUM_DEV    = 4,
    parameter logic [15:0] PRI_BASE   = 16'h004E,
    parameter logic [15:0] ALT_BASE   = 16'h002E,
    parameter logic [7:0]  UNLOCK_KEY = 8'h87,
    parameter logic [7:0]  LOCK_KEY   = 8'hAA,
    parameter logic [15:0] CHIP_ID    = 16'h0C21,
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alt_base,
    input  logic [15:0]           bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  cfg_open,
    output logic [NUM_DEV-1:0]    dev_enable,
    output logic [16*NUM_DEV-1:0] dev_base,
    output logic [8*NUM_DEV-1:0]  dev_irq
);

    localparam int         DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);

    logic [15:0]      active_base;
    logic             hit_idx;
    logic             hit_dat;
    logic             idx_wr;
    logic             dat_wr;
    logic [7:0]       idx_q;
    logic [7:0]       ldn_q;
    field_e           fld;
    logic             bank_ok;
    logic             bank_we;
    logic [7:0]       bank_rd;

    assign active_base = alt_base ? ALT_BASE : PRI_BASE;
    assign hit_idx     = (bus_addr == active_base);
    assign hit_dat     = (bus_addr == active_base + 16'd1);
    assign idx_wr      = bus_wr && hit_idx;
    assign dat_wr      = bus_wr && hit_dat && cfg_open;
    assign fld         = decode_field(idx_q);
    assign bank_ok     = (ldn_q < NUM_DEV_B);
    assign bank_we     = dat_wr && (fld != FLD_NONE) && bank_ok;

    kcp_key_fsm #(
        .UNLOCK_KEY (UNLOCK_KEY),
        .LOCK_KEY   (LOCK_KEY)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (idx_wr && cfg_open && bus_wdata != LOCK_KEY) begin
            idx_q <= bus_wdata;
        end else if (!cfg_open) begin
            idx_q <= 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ldn_q <= 8'h00;
        end else if (dat_wr && idx_q == REG_LDN) begin
            ldn_q <= bus_wdata;
        end
    end

    kcp_dev_bank #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bank_we),
        .dev_sel    (ldn_q[DEV_W-1:0]),
        .field      (fld),
        .wdata      (bus_wdata),
        .rd_data    (bank_rd),
        .dev_enable (dev_enable),
        .dev_base   (dev_base),
        .dev_irq    (dev_irq)
    );

    always_comb begin
        bus_rdata = 8'hFF;
        if (bus_rd && cfg_open) begin
            if (hit_idx) begin
                bus_rdata = idx_q;
            end else if (hit_dat) begin
                case (idx_q)
                    REG_LDN:     bus_rdata = ldn_q;
                    REG_CHIP_HI: bus_rdata = CHIP_ID[15:8];
                    REG_CHIP_LO: bus_rdata = CHIP_ID[7:0];
                    REG_VEND_HI: bus_rdata = VENDOR_ID[15:8];
                    REG_VEND_LO: bus_rdata = VENDOR_ID[7:0];
                    default: begin
                        if (fld == FLD_NONE) bus_rdata = 8'h00;
                        else if (bank_ok)    bus_rdata = bank_rd;
                        else                 bus_rdata = 8'hFF;
                    end
                endcase
            end
        end
    end

    // R9
    stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_idx && !hit_dat) |-> (bus_rdata == 8'hFF));

    // R5
    idx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && cfg_open && bus_wdata != LOCK_KEY) |=> (idx_q == $past(bus_wdata)));

    // R7
    bad_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && cfg_open && hit_dat && fld != FLD_NONE && !bank_ok) |-> (bus_rdata == 8'hFF));

    // R8
    chip_id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && cfg_open && hit_dat && idx_q == REG_CHIP_HI) |-> (bus_rdata == CHIP_ID[15:8]));

endmodule

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;

    localparam int          CLK_PERIOD = 10;
    localparam int          NDEV = 4;
    localparam logic [15:0] PB   = 16'h004E;
    localparam logic [15:0] AB   = 16'h002E;
    localparam logic [7:0]  UK   = 8'h87;
    localparam logic [7:0]  LK   = 8'hAA;
    localparam logic [15:0] CID  = 16'h0C21;
    localparam logic [15:0] VID  = 16'h1A2B;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alt_base = 1'b0;
    logic [15:0]       bus_addr = 16'h0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = 8'h0;
    logic [7:0]        bus_rdata;
    logic              cfg_open;
    logic [NDEV-1:0]   dev_enable;
    logic [16*NDEV-1:0] dev_base;
    logic [8*NDEV-1:0] dev_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural model
    int       mstate = 0;  // 0 locked, 1 armed, 2 open
    bit [7:0] midx = 0;
    bit [7:0] mldn = 0;
    bit [7:0] mreg [NDEV][4];
    bit       malt = 0;

    keyed_cfg_port #(
        .NUM_DEV (NDEV), .PRI_BASE (PB), .ALT_BASE (AB),
        .UNLOCK_KEY (UK), .LOCK_KEY (LK), .CHIP_ID (CID), .VENDOR_ID (VID)
    ) dut (
        .clk (clk), .rst_n (rst_n), .alt_base (alt_base), .bus_addr (bus_addr),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .cfg_open (cfg_open), .dev_enable (dev_enable),
        .dev_base (dev_base), .dev_irq (dev_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int fslot(bit [7:0] i);
        case (i)
            8'h30: return 0;
            8'h60: return 1;
            8'h61: return 2;
            8'h70: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic bit [15:0] mbase();
        return malt ? AB : PB;
    endfunction

    function automatic bit [7:0] mread(bit [15:0] a);
        int s;
        if (mstate != 2) return 8'hFF;
        if (a == mbase()) return midx;
        if (a != mbase() + 16'd1) return 8'hFF;
        case (midx)
            8'h07: return mldn;
            8'h20: return CID[15:8];
            8'h21: return CID[7:0];
            8'h22: return VID[15:8];
            8'h23: return VID[7:0];
            default: ;
        endcase
        s = fslot(midx);
        if (s < 0) return 8'h00;
        if (mldn >= NDEV) return 8'hFF;
        return mreg[mldn][s];
    endfunction

    task automatic mwrite(bit [15:0] a, bit [7:0] d);
        int s;
        if (a == mbase()) begin
            if (mstate == 0) begin
                if (d == UK) mstate = 1;
            end else if (mstate == 1) begin
                mstate = (d == UK) ? 2 : 0;
            end else if (d == LK) begin
                mstate = 0;
                midx = 0;
            end else begin
                midx = d;
            end
        end else if (a == mbase() + 16'd1 && mstate == 2) begin
            s = fslot(midx);
            if (midx == 8'h07) mldn = d;
            else if (s >= 0 && mldn < NDEV) mreg[mldn][s] = d;
        end
    endtask

    task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        logic [NDEV-1:0]    e_en;
        logic [16*NDEV-1:0] e_base;
        logic [8*NDEV-1:0]  e_irq;
        for (int d = 0; d < NDEV; d++) begin
            e_en[d] = mreg[d][0][0];
            e_base[d*16 +: 16] = {mreg[d][1], mreg[d][2]};
            e_irq[d*8 +: 8] = mreg[d][3];
        end
        check(tag, "cfg_open", 64'(cfg_open), 64'(mstate == 2));
        check(tag, "dev_enable", 64'(dev_enable), 64'(e_en));
        check(tag, "dev_base", 64'(dev_base), 64'(e_base));
        check(tag, "dev_irq", 64'(dev_irq), 64'(e_irq));
    endtask

    task automatic op(string tag, bit [15:0] a, bit wr, bit rd, bit [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        alt_base = malt;
        #1;
        if (rd) check(tag, "rdata", 64'(bus_rdata), 64'(mread(a)));
        @(posedge clk);
        #1;
        if (wr) mwrite(a, d);
        bus_wr = 0; bus_rd = 0;
        check_outputs(tag);
    endtask

    task automatic iw(string tag, bit [7:0] d);  op(tag, mbase(), 1, 0, d); endtask
    task automatic dw(string tag, bit [7:0] d);  op(tag, mbase() + 16'd1, 1, 0, d); endtask
    task automatic dr(string tag);               op(tag, mbase() + 16'd1, 0, 1, 8'h00); endtask
    task automatic ir(string tag);               op(tag, mbase(), 0, 1, 8'h00); endtask
    task automatic setreg(string tag, bit [7:0] r, bit [7:0] v); iw(tag, r); dw(tag, v); endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [7:0] v;
        for (int d = 0; d < NDEV; d++)
            for (int k = 0; k < 4; k++) mreg[d][k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_outputs("R1");
        ir("R1"); dr("R1");

        // R3 locked: data writes ignored, abort of half sequence
        dw("R3", 8'h55); dr("R3");
        iw("R3", UK); iw("R3", 8'h07); iw("R3", UK); ir("R3");
        iw("R3", 8'h11);                         // abort from ARMED
        ir("R3");

        // R2 unlock with data traffic in between
        iw("R2", UK); dw("R2", 8'h99); dr("R2"); iw("R2", UK);
        ir("R2");

        // R6 device select and bank registers
        setreg("R6", 8'h07, 8'h01); dr("R6");
        setreg("R6", 8'h30, 8'h5A); dr("R6");
        setreg("R6", 8'h60, 8'h12); setreg("R6", 8'h61, 8'h34);
        setreg("R6", 8'h70, 8'h0A); dr("R6");
        // read-modify-write of one bit in the enable byte
        iw("R6", 8'h30);
        @(negedge clk); v = mread(mbase() + 16'd1);
        dr("R6"); dw("R6", v | 8'h01); dr("R6");
        setreg("R6", 8'h07, 8'h02); iw("R6", 8'h60); dr("R6");
        setreg("R6", 8'h30, 8'h01);

        // R7 out-of-range device
        setreg("R7", 8'h07, 8'h07);
        setreg("R7", 8'h60, 8'hEE); dr("R7");
        setreg("R7", 8'h30, 8'hFF); dr("R7");

        // R8 identity registers
        setreg("R8", 8'h20, 8'h00); dr("R8");
        iw("R8", 8'h21); dr("R8");
        iw("R8", 8'h22); dr("R8");
        iw("R8", 8'h23); dr("R8");

        // R11 unmapped register
        setreg("R11", 8'h55, 8'h3C); dr("R11");

        // R10 same-cycle read and write
        setreg("R10", 8'h07, 8'h01);
        iw("R10", 8'h70);
        op("R10", mbase() + 16'd1, 1, 1, 8'h77);
        dr("R10");
        op("R10", mbase(), 1, 1, 8'h61);
        ir("R10");

        // R9 inactive pair and foreign addresses
        op("R9", AB, 1, 0, LK);
        op("R9", AB + 16'd1, 1, 0, 8'h00);
        op("R9", AB, 0, 1, 8'h00);
        op("R9", 16'h1234, 0, 1, 8'h00);
        dr("R9");

        // R5 index port read-back
        iw("R5", 8'h60); ir("R5"); dr("R5");

        // R4 relock then an immediate data write must be ignored (R3)
        iw("R4", LK); dw("R3", 8'hEE); ir("R4"); dr("R4");
        iw("R4", UK); iw("R4", UK); ir("R4");
        iw("R3", 8'h60); dr("R3");

        // R9 switch to alternate pair
        iw("R9", LK);
        malt = 1;
        op("R9", PB, 1, 0, UK); op("R9", PB, 1, 0, UK); ir("R9");
        iw("R9", UK); iw("R9", UK); ir("R9");
        setreg("R9", 8'h07, 8'h03); setreg("R9", 8'h70, 8'h0F); dr("R9");
        op("R9", PB + 16'd1, 0, 1, 8'h00);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule